// File: doc/BRIEF.md
# Peripheral Reset Control Register

This block holds one reset-state bit for each of a set of shared subordinate blocks and drives their reset lines. A state bit of 1 means its block runs. A state bit of 0 means its block is held in reset. After system reset every controlled block is held in reset, and a management agent releases blocks by writing the register.

The register occupies a 16-byte window at a build-time base address, made of four word views of one storage register. The load view replaces the state. The release view sets bits. The hold view clears bits. The fourth view discards writes. Only requests that carry the privilege qualifier can write. A build option selects either a 14-bit or a 9-bit active map. All other positions are reserved.

Top module: `prst_ctrl`

## Requirements
- R1: After reset every state bit is 0, every active reset output is 1, and read data is 0.
- R2: A privileged write to the load view (byte offset 0x0) sets each active bit to the written value on the next clock edge.
- R3: A privileged write to the release view (offset 0x4) sets active bits written as 1 and leaves bits written as 0 unchanged.
- R4: A privileged write to the hold view (offset 0x8) clears active bits written as 1 and leaves bits written as 0 unchanged.
- R5: A write to the void view (offset 0xC) changes nothing, and a read from it returns 0.
- R6: With FULL_MAP=1 the active bits are 0..8 and 10..14. With FULL_MAP=0 only bits 0..8 are active. Every other bit reads 0 and never changes.
- R7: Reset output bit i equals the inverse of state bit i for active bits and is 0 for reserved bits.
- R8: A write whose privilege qualifier is low has no effect.
- R9: A read of views 0..2 returns the state one cycle after the request. In any other cycle read data is 0. Requests outside the window, or with a byte address not a multiple of 4, have no effect.
- R10: A read in the same cycle as a write returns the state before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_sel | input | 1 | Request valid |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_priv | input | 1 | Privilege qualifier; writes need it high |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| blk_rst | output | 32 | Active-high reset per controlled block |

## Verification
The bench drives bit 9 and the upper reserved bits to 1 on every view. A design that stores them would read them back as 1. The bench writes to the void view, writes without privilege, and writes at unaligned or out-of-window addresses. Decode that is too loose would change the state there. It reads and writes in the same cycle, so a design that forwards the new value fails the check. A second instance with the reduced map catches a mask that ignores the build option. Mixed set and clear patterns catch release and hold views that are swapped or that disturb bits written as 0.

// File: rtl/prst_pkg.sv
package prst_pkg;

   localparam int REG_W = 32;

   typedef enum logic [1:0] {
      VW_LOAD = 2'd0,
      VW_SET  = 2'd1,
      VW_CLR  = 2'd2,
      VW_VOID = 2'd3
   } view_e;

   // Active positions: 0..8 always, 10..14 only with the wide map.
   function automatic logic [REG_W-1:0] active_mask(input bit full_map);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < REG_W; i++) begin
         if (i <= 8)
            m[i] = 1'b1;
         else if (full_map && (i >= 10) && (i <= 14))
            m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/prst_decode.sv
module prst_decode
   import prst_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0060
) (
   input  logic              sel,
   input  logic              wr,
   input  logic              rd,
   input  logic              priv,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_go,
   output logic              rd_go,
   output view_e             view
);

   localparam int WIN_LSB = 4;

   logic in_win;

   always_comb begin
      in_win = sel
             && (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB])
             && (addr[1:0] == 2'b00);
      view   = view_e'(addr[3:2]);
      wr_go  = in_win && wr && priv && (view != VW_VOID);
      rd_go  = in_win && rd && (view != VW_VOID);
   end

endmodule

// File: rtl/prst_state.sv
module prst_state
   import prst_pkg::*;
#(
   parameter bit FULL_MAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_go,
   input  view_e            view,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] state
);

   localparam logic [REG_W-1:0] MASK = active_mask(FULL_MAP);

   logic [REG_W-1:0] nxt;

   always_comb begin
      unique case (view)
         VW_LOAD: nxt = wdata;
         VW_SET:  nxt = state | wdata;
         VW_CLR:  nxt = state & ~wdata;
         default: nxt = state;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= '0;
      else if (wr_go)
         state <= nxt & MASK;
   end

   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state & ~MASK) == '0); // R6

   AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && view == VW_SET) |=> ((state & $past(state)) == $past(state))); // R3

   AST_CLR_ADDS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && view == VW_CLR) |=> ((state & ~$past(state)) == '0)); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_go |=> $stable(state)); // R5

endmodule

// File: rtl/prst_rdport.sv
module prst_rdport
   import prst_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_go,
   input  logic [REG_W-1:0] state,
   output logic [REG_W-1:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else
         rdata <= rd_go ? state : '0;
   end

   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |=> (rdata == $past(state))); // R9

   AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> (rdata == '0)); // R9

endmodule

// File: rtl/prst_ctrl.sv
module prst_ctrl
   import prst_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0060,
   parameter bit                FULL_MAP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_priv,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [31:0]       blk_rst
);

   localparam logic [REG_W-1:0] MASK = active_mask(FULL_MAP);

   if (ADDR_W < 5) begin : g_chk_aw
      $error("prst_ctrl: ADDR_W must be at least 5");
   end
   if (BASE_ADDR[3:0] != 4'h0) begin : g_chk_base
      $error("prst_ctrl: BASE_ADDR must be 16-byte aligned");
   end

   logic             wr_go;
   logic             rd_go;
   view_e            view;
   logic [REG_W-1:0] state;

   prst_decode #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_dec (
      .sel   (bus_sel),
      .wr    (bus_wr),
      .rd    (bus_rd),
      .priv  (bus_priv),
      .addr  (bus_addr),
      .wr_go (wr_go),
      .rd_go (rd_go),
      .view  (view)
   );

   prst_state #(
      .FULL_MAP (FULL_MAP)
   ) u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_go (wr_go),
      .view  (view),
      .wdata (bus_wdata),
      .state (state)
   );

   prst_rdport u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_go (rd_go),
      .state (state),
      .rdata (bus_rdata)
   );

   for (genvar i = 0; i < REG_W; i++) begin : g_out
      if (MASK[i]) begin : g_act
         assign blk_rst[i] = ~state[i];
      end else begin : g_rsv
         assign blk_rst[i] = 1'b0;
      end
   end

   AST_NOPRIV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !bus_priv) |=> $stable(blk_rst)); // R8

   AST_VOID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr[3:2] == 2'b11) |=> $stable(blk_rst)); // R5

   AST_VOID_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_rd && bus_addr[3:2] == 2'b11) |=> (bus_rdata == '0)); // R5

endmodule

// File: tb/sim_prst_ctrl.sv
module sim_prst_ctrl;

   localparam logic [15:0] BASE   = 16'h0060;
   localparam logic [31:0] MASK_A = 32'h0000_7DFF;
   localparam logic [31:0] MASK_B = 32'h0000_01FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0, rd = 1'b0, priv = 1'b0;
   logic [15:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata_a, rst_a, rdata_b, rst_b;

   int    n_cmp = 0;
   int    n_mis = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   prst_ctrl #(.ADDR_W(16), .BASE_ADDR(BASE), .FULL_MAP(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd),
      .bus_priv(priv), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata_a), .blk_rst(rst_a));

   prst_ctrl #(.ADDR_W(16), .BASE_ADDR(BASE), .FULL_MAP(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd),
      .bus_priv(priv), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata_b), .blk_rst(rst_b));

   // Behavioural reference model
   logic [31:0] m_st_a = '0, m_st_b = '0, m_rd_a = '0, m_rd_b = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st_a <= '0; m_st_b <= '0; m_rd_a <= '0; m_rd_b <= '0;
      end else begin
         int  v;
         bit  hit;
         hit = sel && (addr[15:4] == BASE[15:4]) && (addr[1:0] == 2'b00);
         v   = int'(addr[3:2]);
         m_rd_a <= (hit && rd && v != 3) ? m_st_a : 32'h0;
         m_rd_b <= (hit && rd && v != 3) ? m_st_b : 32'h0;
         if (hit && wr && priv) begin
            if (v == 0) begin
               m_st_a <= wdata & MASK_A;
               m_st_b <= wdata & MASK_B;
            end else if (v == 1) begin
               m_st_a <= m_st_a | (wdata & MASK_A);
               m_st_b <= m_st_b | (wdata & MASK_B);
            end else if (v == 2) begin
               m_st_a <= m_st_a & ~(wdata & MASK_A);
               m_st_b <= m_st_b & ~(wdata & MASK_B);
            end
         end
      end
   end

   task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s %s actual=%08h expected=%08h", cur_req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #5;
      cmp("rdata full map", rdata_a, m_rd_a);
      cmp("rdata 9-bit map R6", rdata_b, m_rd_b);
      cmp("R7 blk_rst full map", rst_a, ~m_st_a & MASK_A);
      cmp("R7 blk_rst 9-bit map", rst_b, ~m_st_b & MASK_B);
   end

   task automatic op(input logic s, input logic w, input logic r, input logic p,
                     input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = s; wr = w; rd = r; priv = p; addr = a; wdata = d;
   endtask

   task automatic idle();
      op(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 32'h0);
   endtask

   task automatic wrv(input int v, input logic [31:0] d);
      op(1'b1, 1'b1, 1'b0, 1'b1, BASE + 16'(v * 4), d);
   endtask

   task automatic rdv(input int v);
      op(1'b1, 1'b0, 1'b1, 1'b0, BASE + 16'(v * 4), 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_mis++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rdv(0); idle();

      cur_req = "R2"; wrv(0, 32'hFFFF_FFFF); rdv(0); rdv(1); rdv(2); idle();
      cur_req = "R6"; wrv(1, 32'hFFFF_8200); rdv(0); idle();
      cur_req = "R4"; wrv(2, 32'h0000_0405); rdv(1); idle();
      cur_req = "R3"; wrv(1, 32'h0000_0004); rdv(2); idle();
      cur_req = "R5"; wrv(3, 32'h0000_0000); rdv(3); idle(); rdv(0); idle();
      cur_req = "R8"; op(1'b1, 1'b1, 1'b0, 1'b0, BASE, 32'h0); rdv(0); idle();
      cur_req = "R9"; op(1'b1, 1'b1, 1'b1, 1'b1, BASE + 16'h10, 32'h0);
      op(1'b1, 1'b1, 1'b1, 1'b1, BASE + 16'h1, 32'h0);
      op(1'b0, 1'b1, 1'b1, 1'b1, BASE, 32'h0); rdv(0); idle();
      cur_req = "R10"; op(1'b1, 1'b1, 1'b1, 1'b1, BASE + 16'h8, 32'h0000_0100); rdv(0); idle();
      cur_req = "R2"; wrv(0, 32'h0000_A5A5); rdv(0); wrv(0, 32'h0000_5A5A); rdv(0); idle();

      lfsr = 32'hACE1_1234;
      for (int k = 0; k < 60; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         case (lfsr[3:2])
            2'd0: cur_req = "R2";
            2'd1: cur_req = "R3";
            2'd2: cur_req = "R4";
            default: cur_req = "R5";
         endcase
         op(1'b1, lfsr[4], lfsr[5], lfsr[6] | lfsr[7], BASE + {12'h0, lfsr[3:2], 2'b00},
            {lfsr[15:0], lfsr[31:16]});
      end
      idle();

      cur_req = "R1"; @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      rdv(0); idle(); idle();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

endmodule